// File: doc/BRIEF.md
# Auxiliary-Channel Command Packer

This block sits between a display link controller's request logic and the command FIFO of its auxiliary channel. It takes one request (a 20-bit target address, a direction, a native or I2C-over-AUX selection, optional address and stop suppression, and a byte count), checks it against the size limits, and then loads the FIFO. The load is a four-byte header followed, for writes, by the payload bytes fetched through an index/data port. It then pulses a start strobe together with the transaction-control bits and waits for the channel to report completion.

When a read completes, the block issues a pointer-reset read command to the FIFO, throws away the first word that comes back, and passes the following words out one per cycle. Each delivered byte carries a flag that is raised when the index embedded in the returned word does not match the expected position. Every request ends with a single response pulse that carries an acknowledge, defer or reject code. The block holds busy from the moment a request is accepted until that response has been issued.

Top module: `aux_cmd_packer`

## Requirements
- R1: The first three FIFO words hold the header: word 0 is {3'b000, rd, addr[19:16]} (bit 4 set for a read), word 1 is addr[15:8], and word 2 is addr[7:0].
- R2: The fourth header word is the request length minus one, truncated to 8 bits.
- R3: For a write, payload bytes 0..len-1 follow the header in order, and are fetched by driving pay_idx_o. A read loads the header only. Only the first header word has fifo_idx_reset_o set.
- R4: A request is rejected (resp code 2'b10) with no clear, FIFO write or start in three cases: it is native with len > 16, it has len > 128, or its loaded byte total (4 + payload) exceeds 128.
- R5: A request with len = 0 gets an acknowledge (resp code 2'b00) with no clear, FIFO write or start.
- R6: clear_o pulses for exactly one cycle, immediately before the first header word of every started request.
- R7: After the last loaded word, go_o pulses once. On that pulse, ctrl_i2c_o is the inverse of the native flag, and ctrl_nsa_o and ctrl_nss_o follow the suppression inputs for I2C requests and are 0 for native requests.
- R8: A read that completes successfully writes one read-mode, index-reset command word (data 0). It then pops one FIFO word that it does not deliver, and then pops and delivers len bytes in order on rx_data_o.
- R9: The k-th delivered byte (k from 0) has rx_idx_err_o set exactly when the index returned with it differs from k+1.
- R10: busy_o rises on acceptance and falls the cycle after resp_valid_o. A request presented while busy is ignored and produces no FIFO activity.
- R11: A completion with done_ok_i = 0 gives a defer response (code 2'b01) with no unload. A successful write or read gives an acknowledge (code 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_addr_i | input | 20 | Target address |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_native_i | input | 1 | 1 = native, 0 = I2C-over-AUX |
| req_nsa_i | input | 1 | Suppress address phase (I2C only) |
| req_nss_i | input | 1 | Suppress stop (I2C only) |
| req_len_i | input | 9 | Byte count |
| busy_o | output | 1 | Request in progress |
| pay_idx_o | output | 7 | Payload byte index being fetched |
| pay_data_i | input | 8 | Payload byte at pay_idx_o |
| clear_o | output | 1 | Clear FIFO pointers and pending status |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write byte |
| fifo_idx_reset_o | output | 1 | Reset FIFO index with this write |
| fifo_rmode_o | output | 1 | This write is a read command |
| go_o | output | 1 | Start transfer |
| ctrl_i2c_o | output | 1 | I2C-over-AUX transaction |
| ctrl_nsa_o | output | 1 | No-send-address control |
| ctrl_nss_o | output | 1 | No-send-stop control |
| done_i | input | 1 | Transfer finished |
| done_ok_i | input | 1 | Transfer finished without error |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| fifo_rdata_i | input | 8 | Returned data byte |
| fifo_ridx_i | input | 8 | Index embedded in returned word |
| rx_valid_o | output | 1 | Delivered read byte valid |
| rx_data_o | output | 8 | Delivered read byte |
| rx_idx_err_o | output | 1 | Index mismatch on this byte |
| resp_valid_o | output | 1 | Response pulse |
| resp_code_o | output | 2 | 00 ack, 01 defer, 10 reject |

## Verification
The bench drives native writes and reads whose address nibbles and payloads differ, so that header packing is told apart from payload ordering. It also runs an I2C read at the full 128-byte size with both suppression flags set, which separates the control bits of the two modes. Size requests just inside and just outside each limit (16/17 native, 124/125 I2C write, 128/129 I2C read) show whether the correct ceiling is applied, and the zero-length request shows that the acknowledge path starts nothing. A failed completion, a returned word with a corrupted index, and a request poked in while busy separate defer handling, mismatch flagging and request blocking.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int ADDR_W = 20;
  localparam int HDR_BYTES = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLEAR, ST_LOAD, ST_GO, ST_WAIT,
    ST_RCMD, ST_RDROP, ST_RDATA, ST_RESP
  } st_e;

  typedef enum logic [1:0] {
    RSP_ACK    = 2'b00,
    RSP_DEFER  = 2'b01,
    RSP_REJECT = 2'b10
  } rsp_e;
endpackage

// File: rtl/aux_req_check.sv
module aux_req_check #(
  parameter int LEN_W      = 9,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int FIFO_LIM   = 128,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_i,
  input  logic             native_i,
  output logic             zero_o,
  output logic             reject_o,
  output logic [CNT_W-1:0] total_o
);
  import aux_pkg::*;

  always_comb begin
    total_o  = CNT_W'(HDR_BYTES) + (rd_i ? '0 : CNT_W'(len_i));
    zero_o   = (len_i == '0);
    reject_o = (native_i && (CNT_W'(len_i) > CNT_W'(NATIVE_MAX)))
            || (CNT_W'(len_i) > CNT_W'(I2C_MAX))
            || (total_o > CNT_W'(FIFO_LIM));
  end
endmodule

// File: rtl/aux_byte_sel.sv
module aux_byte_sel #(
  parameter int LEN_W = 9,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [aux_pkg::ADDR_W-1:0] addr_i,
  input  logic                      rd_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [7:0]                pay_i,
  output logic [7:0]                byte_o
);
  logic [LEN_W-1:0] len_m1;

  always_comb begin
    len_m1 = len_i - LEN_W'(1);
    case (cnt_i)
      CNT_W'(0): byte_o = {3'b000, rd_i, addr_i[19:16]};
      CNT_W'(1): byte_o = addr_i[15:8];
      CNT_W'(2): byte_o = addr_i[7:0];
      CNT_W'(3): byte_o = len_m1[7:0];
      default:   byte_o = pay_i;
    endcase
  end
endmodule

// File: rtl/aux_cmd_packer.sv
module aux_cmd_packer #(
  parameter int LEN_W      = 9,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int FIFO_LIM   = 128,
  parameter int IDX_W      = 8,
  localparam int CNT_W     = LEN_W + 1,
  localparam int PAY_W     = $clog2(FIFO_LIM)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [aux_pkg::ADDR_W-1:0]  req_addr_i,
  input  logic                        req_rd_i,
  input  logic                        req_native_i,
  input  logic                        req_nsa_i,
  input  logic                        req_nss_i,
  input  logic [LEN_W-1:0]            req_len_i,
  output logic                        busy_o,
  output logic [PAY_W-1:0]            pay_idx_o,
  input  logic [7:0]                  pay_data_i,
  output logic                        clear_o,
  output logic                        fifo_wr_o,
  output logic [7:0]                  fifo_wdata_o,
  output logic                        fifo_idx_reset_o,
  output logic                        fifo_rmode_o,
  output logic                        go_o,
  output logic                        ctrl_i2c_o,
  output logic                        ctrl_nsa_o,
  output logic                        ctrl_nss_o,
  input  logic                        done_i,
  input  logic                        done_ok_i,
  output logic                        fifo_rd_o,
  input  logic [7:0]                  fifo_rdata_i,
  input  logic [IDX_W-1:0]            fifo_ridx_i,
  output logic                        rx_valid_o,
  output logic [7:0]                  rx_data_o,
  output logic                        rx_idx_err_o,
  output logic                        resp_valid_o,
  output logic [1:0]                  resp_code_o
);
  import aux_pkg::*;

  st_e                  state_q;
  rsp_e                 rsp_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     total_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 rd_q, native_q, nsa_q, nss_q;
  logic [LEN_W-1:0]     len_q;

  logic                 chk_zero, chk_reject;
  logic [CNT_W-1:0]     chk_total;
  logic [7:0]           sel_byte;
  logic [CNT_W-1:0]     exp_idx;

  aux_req_check #(
    .LEN_W(LEN_W), .NATIVE_MAX(NATIVE_MAX), .I2C_MAX(I2C_MAX), .FIFO_LIM(FIFO_LIM)
  ) u_check (
    .len_i    (req_len_i),
    .rd_i     (req_rd_i),
    .native_i (req_native_i),
    .zero_o   (chk_zero),
    .reject_o (chk_reject),
    .total_o  (chk_total)
  );

  aux_byte_sel #(.LEN_W(LEN_W)) u_sel (
    .cnt_i  (cnt_q),
    .addr_i (addr_q),
    .rd_i   (rd_q),
    .len_i  (len_q),
    .pay_i  (pay_data_i),
    .byte_o (sel_byte)
  );

  assign exp_idx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rsp_q    <= RSP_ACK;
      cnt_q    <= '0;
      total_q  <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      native_q <= 1'b0;
      nsa_q    <= 1'b0;
      nss_q    <= 1'b0;
      len_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q   <= req_addr_i;
          rd_q     <= req_rd_i;
          native_q <= req_native_i;
          nsa_q    <= req_nsa_i;
          nss_q    <= req_nss_i;
          len_q    <= req_len_i;
          total_q  <= chk_total;
          cnt_q    <= '0;
          if (chk_zero) begin
            rsp_q   <= RSP_ACK;
            state_q <= ST_RESP;
          end else if (chk_reject) begin
            rsp_q   <= RSP_REJECT;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_CLEAR;
          end
        end
        ST_CLEAR: state_q <= ST_LOAD;
        ST_LOAD: begin
          if (cnt_q == total_q - CNT_W'(1)) state_q <= ST_GO;
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_GO: state_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (!done_ok_i) begin
            rsp_q   <= RSP_DEFER;
            state_q <= ST_RESP;
          end else if (rd_q) begin
            state_q <= ST_RCMD;
          end else begin
            rsp_q   <= RSP_ACK;
            state_q <= ST_RESP;
          end
        end
        ST_RCMD: begin
          cnt_q   <= '0;
          state_q <= ST_RDROP;
        end
        ST_RDROP: state_q <= ST_RDATA;
        ST_RDATA: begin
          if (cnt_q == CNT_W'(len_q) - CNT_W'(1)) begin
            rsp_q   <= RSP_ACK;
            state_q <= ST_RESP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o           = (state_q != ST_IDLE);
    clear_o          = (state_q == ST_CLEAR);
    fifo_wr_o        = (state_q == ST_LOAD) || (state_q == ST_RCMD);
    fifo_rmode_o     = (state_q == ST_RCMD);
    fifo_idx_reset_o = fifo_rmode_o || ((state_q == ST_LOAD) && (cnt_q == '0));
    fifo_wdata_o     = (state_q == ST_LOAD) ? sel_byte : 8'h00;
    pay_idx_o        = (state_q == ST_LOAD) ? PAY_W'(cnt_q - CNT_W'(HDR_BYTES)) : '0;
    go_o             = (state_q == ST_GO);
    ctrl_i2c_o       = go_o && !native_q;
    ctrl_nsa_o       = ctrl_i2c_o && nsa_q;
    ctrl_nss_o       = ctrl_i2c_o && nss_q;
    fifo_rd_o        = (state_q == ST_RDROP) || (state_q == ST_RDATA);
    rx_valid_o       = (state_q == ST_RDATA);
    rx_data_o        = rx_valid_o ? fifo_rdata_i : 8'h00;
    rx_idx_err_o     = rx_valid_o && (fifo_ridx_i != IDX_W'(exp_idx));
    resp_valid_o     = (state_q == ST_RESP);
    resp_code_o      = resp_valid_o ? rsp_q : 2'b00;
  end
endmodule

// File: rtl/aux_cmd_packer_chk.sv
module aux_cmd_packer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic clear_o,
  input logic fifo_wr_o,
  input logic fifo_idx_reset_o,
  input logic fifo_rmode_o,
  input logic go_o,
  input logic ctrl_i2c_o,
  input logic ctrl_nsa_o,
  input logic ctrl_nss_o,
  input logic fifo_rd_o,
  input logic rx_valid_o,
  input logic resp_valid_o
);
  assert_clear_then_hdr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (fifo_wr_o && fifo_idx_reset_o && !fifo_rmode_o && !clear_o));

  assert_go_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> (!go_o && busy_o));

  assert_ctrl_i2c_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (ctrl_i2c_o || (!ctrl_nsa_o && !ctrl_nss_o)));

  assert_rcmd_form_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rmode_o |-> (fifo_wr_o && fifo_idx_reset_o));

  assert_drop_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && fifo_rmode_o) |=> (fifo_rd_o && !rx_valid_o));

  assert_rx_pops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> fifo_rd_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(fifo_wr_o || go_o || fifo_rd_o || clear_o || resp_valid_o));

  assert_resp_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !busy_o);
endmodule

bind aux_cmd_packer aux_cmd_packer_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busy_o           (busy_o),
  .clear_o          (clear_o),
  .fifo_wr_o        (fifo_wr_o),
  .fifo_idx_reset_o (fifo_idx_reset_o),
  .fifo_rmode_o     (fifo_rmode_o),
  .go_o             (go_o),
  .ctrl_i2c_o       (ctrl_i2c_o),
  .ctrl_nsa_o       (ctrl_nsa_o),
  .ctrl_nss_o       (ctrl_nss_o),
  .fifo_rd_o        (fifo_rd_o),
  .rx_valid_o       (rx_valid_o),
  .resp_valid_o     (resp_valid_o)
);

// File: tb/sim_aux_cmd_packer.sv
`timescale 1ns/1ps
module sim_aux_cmd_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_rd = 1'b0, req_native = 1'b0, req_nsa = 1'b0, req_nss = 1'b0;
  logic [8:0]  req_len = '0;
  logic        busy;
  logic [6:0]  pay_idx;
  logic [7:0]  pay_data;
  logic        clear, fifo_wr, fifo_idx_reset, fifo_rmode;
  logic [7:0]  fifo_wdata;
  logic        go, ctrl_i2c, ctrl_nsa, ctrl_nss;
  logic        done = 1'b0, done_ok = 1'b0;
  logic        fifo_rd;
  logic [7:0]  fifo_rdata, fifo_ridx;
  logic        rx_valid, rx_idx_err;
  logic [7:0]  rx_data;
  logic        resp_valid;
  logic [1:0]  resp_code;

  always #2.5 clk = ~clk;

  aux_cmd_packer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_rd_i(req_rd),
    .req_native_i(req_native), .req_nsa_i(req_nsa), .req_nss_i(req_nss),
    .req_len_i(req_len), .busy_o(busy), .pay_idx_o(pay_idx), .pay_data_i(pay_data),
    .clear_o(clear), .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata),
    .fifo_idx_reset_o(fifo_idx_reset), .fifo_rmode_o(fifo_rmode),
    .go_o(go), .ctrl_i2c_o(ctrl_i2c), .ctrl_nsa_o(ctrl_nsa), .ctrl_nss_o(ctrl_nss),
    .done_i(done), .done_ok_i(done_ok), .fifo_rd_o(fifo_rd),
    .fifo_rdata_i(fifo_rdata), .fifo_ridx_i(fifo_ridx),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_idx_err_o(rx_idx_err),
    .resp_valid_o(resp_valid), .resp_code_o(resp_code)
  );

  // payload source and returned-data model
  logic [7:0] pay_mem [0:127];
  logic [7:0] rx_mem  [0:255];
  int         rd_ptr = 0;
  int         bad_at = -1;
  initial for (int i = 0; i < 256; i++) begin
    rx_mem[i] = 8'(i * 7 + 3);
    if (i < 128) pay_mem[i] = 8'(i * 13 + 1);
  end
  assign pay_data   = pay_mem[pay_idx];
  assign fifo_rdata = rx_mem[rd_ptr[7:0]];
  assign fifo_ridx  = (rd_ptr == bad_at) ? (8'(rd_ptr) ^ 8'h40) : 8'(rd_ptr);
  always @(posedge clk) begin
    if (fifo_wr && fifo_idx_reset) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [9:0] exp_wr [$];
  string      wr_tag [$];
  logic [2:0] exp_go [$];
  logic [8:0] exp_rx [$];
  logic [1:0] exp_rsp [$];
  bit         clr_pend = 0;

  always @(negedge clk) if (rst_n) begin
    if (clear) begin
      check(exp_wr.size() != 0, "R6 clear without load (R4/R5)", 1, 0);
      clr_pend = 1;
    end
    if (fifo_wr) begin
      if (exp_wr.size() == 0) check(0, "R10 unexpected fifo write", {22'd0, fifo_rmode, fifo_idx_reset, fifo_wdata}, 0);
      else begin
        logic [9:0] e;
        string t;
        e = exp_wr.pop_front();
        t = wr_tag.pop_front();
        check({fifo_rmode, fifo_idx_reset, fifo_wdata} == e, t, {fifo_rmode, fifo_idx_reset, fifo_wdata}, e);
        if (fifo_idx_reset && !fifo_rmode) begin
          check(clr_pend, "R6 clear before header", 0, 1);
          clr_pend = 0;
        end
      end
    end
    if (go) begin
      if (exp_go.size() == 0) check(0, "R7 unexpected go", 1, 0);
      else begin
        logic [2:0] g;
        g = exp_go.pop_front();
        check({ctrl_i2c, ctrl_nsa, ctrl_nss} == g, "R7 ctrl bits", {ctrl_i2c, ctrl_nsa, ctrl_nss}, g);
      end
    end
    if (rx_valid) begin
      if (exp_rx.size() == 0) check(0, "R8 unexpected rx byte", rx_data, 0);
      else begin
        logic [8:0] r;
        r = exp_rx.pop_front();
        check({rx_idx_err, rx_data} == r, "R8 R9 rx byte", {rx_idx_err, rx_data}, r);
      end
    end
    if (resp_valid) begin
      if (exp_rsp.size() == 0) check(0, "R11 unexpected resp", resp_code, 0);
      else begin
        logic [1:0] c;
        c = exp_rsp.pop_front();
        check(resp_code == c, "R4 R5 R11 resp code", resp_code, c);
      end
    end
  end

  task automatic send(input logic [19:0] a, input bit rd, input bit nat, input bit nsa,
                      input bit nss, input int len, input bit ok, input int bad, input bit poke);
    bit zero, rej, act;
    int total;
    zero  = (len == 0);
    total = 4 + (rd ? 0 : len);
    rej   = !zero && ((nat && len > 16) || len > 128 || total > 128);
    act   = !zero && !rej;
    if (zero) exp_rsp.push_back(2'b00);
    else if (rej) exp_rsp.push_back(2'b10);
    else begin
      logic [8:0] lm1;
      lm1 = 9'(len - 1);
      exp_wr.push_back({2'b01, 3'b000, rd, a[19:16]}); wr_tag.push_back("R1 hdr0");
      exp_wr.push_back({2'b00, a[15:8]});              wr_tag.push_back("R1 hdr1");
      exp_wr.push_back({2'b00, a[7:0]});               wr_tag.push_back("R1 hdr2");
      exp_wr.push_back({2'b00, lm1[7:0]});             wr_tag.push_back("R2 hdr3");
      if (!rd) for (int i = 0; i < len; i++) begin
        exp_wr.push_back({2'b00, pay_mem[i]}); wr_tag.push_back("R3 payload");
      end
      exp_go.push_back({!nat, !nat && nsa, !nat && nss});
      if (!ok) exp_rsp.push_back(2'b01);
      else begin
        if (rd) begin
          exp_wr.push_back(10'b11_0000_0000); wr_tag.push_back("R8 read cmd");
          for (int k = 0; k < len; k++) exp_rx.push_back({(bad == k + 1), rx_mem[k + 1]});
        end
        exp_rsp.push_back(2'b00);
      end
    end
    bad_at = bad;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_addr = a; req_rd = rd; req_native = nat; req_nsa = nsa; req_nss = nss;
    req_len = 9'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (act) begin
      while (!go) @(negedge clk);
      if (poke) begin
        req_addr = 20'hFFFFF; req_rd = 1'b0; req_native = 1'b1; req_len = 9'd2;
        req_valid = 1'b1;
      end
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      if (poke) check(busy == 1'b1, "R10 busy while waiting", busy, 1);
      done = 1'b1; done_ok = ok;
      @(negedge clk);
      done = 1'b0; done_ok = 1'b0;
    end
    while (busy) @(negedge clk);
    check(!busy, "R10 busy released", busy, 0);
  endtask

  task automatic finish_run();
    check(exp_wr.size() == 0 && exp_go.size() == 0, "R3 R7 pending fifo/go items", exp_wr.size() + exp_go.size(), 0);
    check(exp_rx.size() == 0, "R8 pending rx items", exp_rx.size(), 0);
    check(exp_rsp.size() == 0, "R11 pending responses", exp_rsp.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, fifo_wr, go, resp_valid, clear} == 5'b0, "R10 reset state", {busy, fifo_wr, go, resp_valid, clear}, 0);
    send(20'h12345, 0, 1, 0, 0,   3, 1, -1, 0); // R1 R2 R3 native write
    send(20'hABCDE, 1, 1, 0, 0,  16, 1, -1, 0); // R8 native read at limit
    send(20'h00010, 1, 1, 0, 0,  17, 1, -1, 0); // R4 native over limit
    send(20'h00050, 1, 0, 1, 1, 128, 1, -1, 0); // R7 R8 i2c read at limit
    send(20'h00050, 0, 0, 0, 1, 125, 1, -1, 0); // R4 total over 128
    send(20'h00050, 0, 0, 1, 0, 124, 1, -1, 0); // R3 total exactly 128
    send(20'h00050, 1, 0, 0, 0, 129, 1, -1, 0); // R4 over i2c limit
    send(20'h00777, 1, 0, 0, 0,   0, 1, -1, 0); // R5 zero length
    send(20'h9F00F, 1, 1, 0, 0,   4, 0, -1, 0); // R11 failed completion
    send(20'h00123, 1, 0, 0, 0,   5, 1,  2, 0); // R9 index mismatch on byte 1
    send(20'h40000, 0, 1, 1, 1,   1, 1, -1, 1); // R7 native ignores flags, R10 poke
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule